// File: doc/BRIEF.md
# Interrupt and Exception Entry/Return Sequencer

This block is the control unit that moves a small 16-bit processor into a service routine and back again. When the instruction datapath reports that one instruction has finished and the next has not yet been fetched, the sequencer may take one of three requests. An external interrupt carries an 8-bit vector and a 3-bit priority. An internal exception carries only a vector. A return command restores the interrupted program. The sequencer owns the status word, the program counter, the stack-pointer register and the two parked stack pointers. It reaches memory through a simple word-addressed port whose read data is valid in the same cycle as the request.

On entry, the sequencer switches to the supervisor stack if the program was in user mode. It then pushes the old status word and the old program counter. It rewrites the status word to supervisor mode with the new priority and cleared flags. Finally, it loads the handler address from a vector table. On return, it pops the program counter and then the status word. If the restored status word is in user mode, it parks the supervisor stack pointer and brings the user stack pointer back. A return command issued in user mode is a privilege violation. The sequencer turns it into an exception entry instead of a return.

Top module: `irq_stack_seq`

## Requirements
- R1: While `rst_n` is low and just after it rises, `psr` equals PSR_RST (default 16'h8002), `pc` equals PC_RST (16'h3006), `r6` equals R6_RST (16'h4000), `saved_ssp` equals SSP_RST (16'h3000), `saved_usp` is 0 and `busy` is 0.
- R2: A request is taken only in a cycle where `boundary` is 1 and `busy` is 0. Any request seen in another cycle is dropped. An entry holds `busy` high for 3 cycles and a return for 2 cycles.
- R3: An interrupt is taken only if `irq_prio` is strictly greater than the current level in `psr[10:8]`. A request at an equal or lower level leaves every register unchanged.
- R4: The user/supervisor bit is `psr[15]`, with 1 meaning user. On entry from user mode, `saved_usp` gets the old `r6` and `r6` gets `saved_ssp` before anything is pushed. On entry from supervisor mode, neither stack pointer is swapped.
- R5: Each push first decrements `r6` and then writes to the word at the new `r6`. The old `psr` is pushed first and the old `pc` second, so an entry lowers `r6` by 2.
- R6: Once both words are pushed, `psr[15]` and `psr[2:0]` are cleared and `psr[10:8]` takes the serviced level. All other `psr` bits are kept.
- R7: The last entry step reads the word at address VEC_BASE (16'h0100) plus the 8-bit vector, and that word becomes `pc`.
- R8: An exception keeps the current level in `psr[10:8]`. When an exception, a return and an interrupt are all presented in one cycle, the exception is taken. A return outranks an interrupt.
- R9: A return reads `pc` from the word at `r6` and then `psr` from the word at `r6`+1. `r6` is incremented after each read.
- R10: If the restored `psr[15]` is 1, `saved_ssp` gets the incremented `r6` and `r6` gets `saved_usp` in the same cycle.
- R11: A return command while `psr[15]` is 1 performs an exception entry with vector PRIV_VEC (8'h00) instead of popping.
- R12: Entries nest. A higher-level interrupt taken inside a handler pushes onto the supervisor stack without a swap. Successive returns unwind both levels back to the user program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | High between the end of one instruction and the next fetch |
| irq_req | input | 1 | External interrupt request |
| irq_vec | input | 8 | Interrupt vector |
| irq_prio | input | 3 | Interrupt priority level |
| exc_req | input | 1 | Internal exception request |
| exc_vec | input | 8 | Exception vector |
| rti_req | input | 1 | Return-from-interrupt command |
| mem_rdata | input | 16 | Memory read data, valid in the request cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| psr | output | 16 | Processor status word |
| pc | output | 16 | Program counter |
| r6 | output | 16 | Stack-pointer register |
| saved_usp | output | 16 | Parked user stack pointer |
| saved_ssp | output | 16 | Parked supervisor stack pointer |
| busy | output | 1 | Sequence in progress |

## Verification
Requests at an equal level, at a lower level, and with `boundary` low must produce no change. A higher level then triggers a full entry, which separates the strict-greater rule from a greater-or-equal rule and shows that the boundary gate works. The test nests a second interrupt inside the first handler and then presents an exception, a return and an interrupt together. This exposes a stack swap done from supervisor mode, a wrong push order, and a wrong arbitration order. Three returns unwind the stack, and the last one lands in user mode, which tests the stack-pointer exchange. A final return command issued in user mode has to enter the privilege handler rather than pop.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int unsigned DW        = 16;
  localparam int unsigned VW        = 8;
  localparam int unsigned LW        = 3;
  localparam int unsigned PRIV_BIT  = 15;
  localparam int unsigned LVL_LSB   = 8;
  localparam int unsigned CC_W      = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_PSR,
    S_PUSH_PC,
    S_VECTOR,
    S_POP_PC,
    S_POP_PSR
  } seq_state_e;

  // status word once the old state is on the stack
  function automatic logic [DW-1:0] entry_psr(input logic [DW-1:0] old,
                                              input logic [LW-1:0] lvl);
    logic [DW-1:0] n;
    n = old;
    n[PRIV_BIT] = 1'b0;
    n[LVL_LSB +: LW] = lvl;
    n[CC_W-1:0] = '0;
    return n;
  endfunction

  // pre-decrement stack slot
  function automatic logic [DW-1:0] push_slot(input logic [DW-1:0] sp);
    return sp - 1'b1;
  endfunction

  function automatic logic [DW-1:0] table_addr(input logic [DW-1:0] base,
                                               input logic [VW-1:0] vec);
    return base + {{(DW-VW){1'b0}}, vec};
  endfunction

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter logic [VW-1:0] PRIV_VEC = 8'h00
) (
  input  logic          boundary,
  input  logic          busy,
  input  logic          user_mode,
  input  logic [LW-1:0] cur_lvl,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic [LW-1:0] irq_prio,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          rti_req,
  output logic          exc_taken,
  output logic          priv_fault,
  output logic          irq_taken,
  output logic          ret_taken,
  output logic          entry_taken,
  output logic [VW-1:0] sel_vec,
  output logic [LW-1:0] sel_lvl
);
  logic open_slot;

  always_comb begin
    open_slot   = boundary && !busy;
    exc_taken   = open_slot && exc_req;
    priv_fault  = open_slot && !exc_req && rti_req && user_mode;
    ret_taken   = open_slot && !exc_req && rti_req && !user_mode;
    irq_taken   = open_slot && !exc_req && !rti_req && irq_req && (irq_prio > cur_lvl);
    entry_taken = exc_taken || priv_fault || irq_taken;
    if (exc_req)      sel_vec = exc_vec;
    else if (rti_req) sel_vec = PRIV_VEC;
    else              sel_vec = irq_vec;
    sel_lvl = irq_taken ? irq_prio : cur_lvl;
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_taken,
  input  logic       ret_taken,
  output seq_state_e state,
  output logic       busy
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (entry_taken)    nxt = S_PUSH_PSR;
        else if (ret_taken) nxt = S_POP_PC;
      end
      S_PUSH_PSR: nxt = S_PUSH_PC;
      S_PUSH_PC:  nxt = S_VECTOR;
      S_VECTOR:   nxt = S_IDLE;
      S_POP_PC:   nxt = S_POP_PSR;
      S_POP_PSR:  nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] PC_RST   = 16'h3006,
  parameter logic [15:0] PSR_RST  = 16'h8002,
  parameter logic [15:0] R6_RST   = 16'h4000,
  parameter logic [15:0] SSP_RST  = 16'h3000,
  parameter logic [15:0] VEC_BASE = 16'h0100,
  parameter logic [7:0]  PRIV_VEC = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        irq_req,
  input  logic [7:0]  irq_vec,
  input  logic [2:0]  irq_prio,
  input  logic        exc_req,
  input  logic [7:0]  exc_vec,
  input  logic        rti_req,
  input  logic [15:0] mem_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [15:0] psr,
  output logic [15:0] pc,
  output logic [15:0] r6,
  output logic [15:0] saved_usp,
  output logic [15:0] saved_ssp,
  output logic        busy
);
  seq_state_e    state;
  logic          exc_taken, priv_fault, irq_taken, ret_taken, entry_taken;
  logic [VW-1:0] sel_vec, vec_q;
  logic [LW-1:0] sel_lvl, lvl_q;
  logic          pop_pc_step;

  irq_seq_arb #(.PRIV_VEC(PRIV_VEC)) u_arb (
    .boundary    (boundary),
    .busy        (busy),
    .user_mode   (psr[PRIV_BIT]),
    .cur_lvl     (psr[LVL_LSB +: LW]),
    .irq_req     (irq_req),
    .irq_vec     (irq_vec),
    .irq_prio    (irq_prio),
    .exc_req     (exc_req),
    .exc_vec     (exc_vec),
    .rti_req     (rti_req),
    .exc_taken   (exc_taken),
    .priv_fault  (priv_fault),
    .irq_taken   (irq_taken),
    .ret_taken   (ret_taken),
    .entry_taken (entry_taken),
    .sel_vec     (sel_vec),
    .sel_lvl     (sel_lvl)
  );

  irq_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_taken (entry_taken),
    .ret_taken   (ret_taken),
    .state       (state),
    .busy        (busy)
  );

  assign pop_pc_step = (state == S_POP_PC);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = r6;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_PSR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = push_slot(r6); mem_wdata = psr;
      end
      S_PUSH_PC: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = push_slot(r6); mem_wdata = pc;
      end
      S_VECTOR: begin
        mem_req = 1'b1;
        mem_addr = table_addr(VEC_BASE, vec_q);
      end
      S_POP_PC, S_POP_PSR: mem_req = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr       <= PSR_RST;
      pc        <= PC_RST;
      r6        <= R6_RST;
      saved_usp <= '0;
      saved_ssp <= SSP_RST;
      vec_q     <= '0;
      lvl_q     <= '0;
    end else begin
      if (entry_taken) begin
        vec_q <= sel_vec;
        lvl_q <= sel_lvl;
        if (psr[PRIV_BIT]) begin
          saved_usp <= r6;
          r6        <= saved_ssp;
        end
      end
      unique case (state)
        S_PUSH_PSR: r6 <= push_slot(r6);
        S_PUSH_PC: begin
          r6  <= push_slot(r6);
          psr <= entry_psr(psr, lvl_q);
        end
        S_VECTOR: pc <= mem_rdata;
        S_POP_PC: begin
          pc <= mem_rdata;
          r6 <= r6 + 1'b1;
        end
        S_POP_PSR: begin
          psr <= mem_rdata;
          if (mem_rdata[PRIV_BIT]) begin
            saved_ssp <= r6 + 1'b1;
            r6        <= saved_usp;
          end else begin
            r6 <= r6 + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        busy,
  input logic [2:0]  irq_prio,
  input logic [15:0] psr,
  input logic [15:0] r6,
  input logic        mem_req,
  input logic        mem_we,
  input logic        irq_taken,
  input logic        exc_taken,
  input logic        ret_taken,
  input logic        entry_taken,
  input logic        priv_fault,
  input logic        pop_pc_step
);
  a_r2_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_taken || ret_taken) |-> (boundary && !busy));

  a_r3_prio_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> (irq_prio > psr[10:8]));

  a_r5_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (r6 == $past(r6) - 16'd1));

  a_r5_write_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  a_r6_supervisor_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    entry_taken |-> ##3 !psr[15]);

  a_r8_exc_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> ##3 (psr[10:8] == $past(psr[10:8], 3)));

  a_r9_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pc_step |=> (r6 == $past(r6) + 16'd1));

  a_r11_fault_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> (mem_req && mem_we));
endmodule

bind irq_stack_seq irq_stack_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boundary    (boundary),
  .busy        (busy),
  .irq_prio    (irq_prio),
  .psr         (psr),
  .r6          (r6),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .irq_taken   (irq_taken),
  .exc_taken   (exc_taken),
  .ret_taken   (ret_taken),
  .entry_taken (entry_taken),
  .priv_fault  (priv_fault),
  .pop_pc_step (pop_pc_step)
);

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        boundary = 1'b0, irq_req = 1'b0, exc_req = 1'b0, rti_req = 1'b0;
  logic [7:0]  irq_vec = '0, exc_vec = '0;
  logic [2:0]  irq_prio = '0;
  logic [15:0] mem_rdata;
  logic        mem_req, mem_we, busy;
  logic [15:0] mem_addr, mem_wdata, psr, pc, r6, saved_usp, saved_ssp;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio),
    .exc_req(exc_req), .exc_vec(exc_vec), .rti_req(rti_req),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .psr(psr), .pc(pc),
    .r6(r6), .saved_usp(saved_usp), .saved_ssp(saved_ssp), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // environment memory driven by the design
  logic [15:0] emem [int];
  always @(*) mem_rdata = emem.exists(int'(mem_addr)) ? emem[int'(mem_addr)] : 16'h0000;
  always @(posedge clk) if (mem_req && mem_we) emem[int'(mem_addr)] = mem_wdata;

  // behavioural reference: queue of pending steps, own memory
  localparam int OP_PSH_PSR = 1, OP_PSH_PC = 2, OP_LOAD_VEC = 3, OP_POP_PC = 4, OP_POP_PSR = 5;
  logic [15:0] m_psr, m_pc, m_r6, m_usp, m_ssp;
  logic [7:0]  m_vec;
  logic [2:0]  m_lvl;
  int          m_q[$];
  logic [15:0] mmem [int];

  function automatic logic [15:0] mrd(input int a);
    return mmem.exists(a) ? mmem[a] : 16'h0000;
  endfunction

  task automatic m_enter(input logic [7:0] v, input logic [2:0] l);
    m_vec = v; m_lvl = l;
    if (m_psr[15]) begin m_usp = m_r6; m_r6 = m_ssp; end
    m_q.push_back(OP_PSH_PSR); m_q.push_back(OP_PSH_PC); m_q.push_back(OP_LOAD_VEC);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psr = 16'h8002; m_pc = 16'h3006; m_r6 = 16'h4000;
      m_usp = 16'h0000; m_ssp = 16'h3000; m_q.delete();
    end else if (m_q.size() != 0) begin
      int op;
      op = m_q.pop_front();
      case (op)
        OP_PSH_PSR: begin m_r6 = m_r6 - 16'd1; mmem[int'(m_r6)] = m_psr; end
        OP_PSH_PC: begin
          m_r6 = m_r6 - 16'd1; mmem[int'(m_r6)] = m_pc;
          m_psr = (m_psr & 16'h78F8) | ({13'd0, m_lvl} << 8);
        end
        OP_LOAD_VEC: m_pc = mrd(256 + int'(m_vec));
        OP_POP_PC: begin m_pc = mrd(int'(m_r6)); m_r6 = m_r6 + 16'd1; end
        default: begin
          m_psr = mrd(int'(m_r6)); m_r6 = m_r6 + 16'd1;
          if (m_psr[15]) begin m_ssp = m_r6; m_r6 = m_usp; end
        end
      endcase
    end else if (boundary) begin
      if (exc_req) m_enter(exc_vec, m_psr[10:8]);
      else if (rti_req) begin
        if (m_psr[15]) m_enter(8'h00, m_psr[10:8]);
        else begin m_q.push_back(OP_POP_PC); m_q.push_back(OP_POP_PSR); end
      end else if (irq_req && (int'(irq_prio) > int'(m_psr[10:8])))
        m_enter(irq_vec, irq_prio);
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 psr vs model", psr, m_psr);
      chk("R7 pc vs model", pc, m_pc);
      chk("R5 r6 vs model", r6, m_r6);
      chk("R4 saved_usp vs model", saved_usp, m_usp);
      chk("R10 saved_ssp vs model", saved_ssp, m_ssp);
      chk("R2 busy vs model", {15'd0, busy}, {15'd0, (m_q.size() != 0)});
    end
  end

  task automatic fire(input logic b, input logic ir, input logic [7:0] iv, input logic [2:0] ip,
                      input logic ex, input logic [7:0] ev, input logic rt);
    @(negedge clk);
    boundary = b; irq_req = ir; irq_vec = iv; irq_prio = ip;
    exc_req = ex; exc_vec = ev; rti_req = rt;
    @(negedge clk);
    boundary = 1'b0; irq_req = 1'b0; exc_req = 1'b0; rti_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic seed(input int a, input logic [15:0] d);
    emem[a] = d; mmem[a] = d;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    seed(16'h0180, 16'h1000);
    seed(16'h0181, 16'h1100);
    seed(16'h0100, 16'h1200);
    seed(16'h0105, 16'h1300);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 psr", psr, 16'h8002);
    chk("R1 pc", pc, 16'h3006);
    chk("R1 r6", r6, 16'h4000);
    chk("R1 ssp", saved_ssp, 16'h3000);
    chk("R1 usp", saved_usp, 16'h0000);
    chk("R1 busy", {15'd0, busy}, 16'h0);

    // R2 request without boundary ignored
    fire(1'b0, 1'b1, 8'h80, 3'd4, 1'b0, 8'h00, 1'b0);
    chk("R2 no boundary pc", pc, 16'h3006);
    // R3 equal level ignored
    fire(1'b1, 1'b1, 8'h80, 3'd0, 1'b0, 8'h00, 1'b0);
    chk("R3 equal level pc", pc, 16'h3006);

    // first entry from user mode
    fire(1'b1, 1'b1, 8'h80, 3'd4, 1'b0, 8'h00, 1'b0);
    chk("R4 usp parked", saved_usp, 16'h4000);
    chk("R5 r6 after push", r6, 16'h2FFE);
    chk("R5 psr pushed first", emem[16'h2FFF], 16'h8002);
    chk("R5 pc pushed second", emem[16'h2FFE], 16'h3006);
    chk("R6 psr after entry", psr, 16'h0400);
    chk("R7 handler pc", pc, 16'h1000);

    // R3 lower level ignored
    fire(1'b1, 1'b1, 8'h81, 3'd3, 1'b0, 8'h00, 1'b0);
    chk("R3 lower level pc", pc, 16'h1000);

    // R12 nested entry from supervisor
    fire(1'b1, 1'b1, 8'h81, 3'd6, 1'b0, 8'h00, 1'b0);
    chk("R12 nested pc", pc, 16'h1100);
    chk("R12 nested r6", r6, 16'h2FFC);
    chk("R12 usp untouched", saved_usp, 16'h4000);
    chk("R12 nested saved psr", emem[16'h2FFD], 16'h0400);

    // R8 exception wins, keeps level
    fire(1'b1, 1'b1, 8'h80, 3'd7, 1'b1, 8'h05, 1'b1);
    chk("R8 exception pc", pc, 16'h1300);
    chk("R8 exception level", psr, 16'h0600);
    chk("R8 exception r6", r6, 16'h2FFA);

    // R9 returns
    fire(1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1);
    chk("R9 pop pc", pc, 16'h1100);
    chk("R9 pop psr", psr, 16'h0600);
    chk("R9 r6 after pop", r6, 16'h2FFC);
    fire(1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1);
    chk("R12 unwind pc", pc, 16'h1000);
    chk("R12 unwind psr", psr, 16'h0400);
    fire(1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1);
    chk("R10 user pc", pc, 16'h3006);
    chk("R10 user psr", psr, 16'h8002);
    chk("R10 ssp parked", saved_ssp, 16'h3000);
    chk("R10 r6 restored", r6, 16'h4000);

    // R11 return in user mode
    fire(1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1);
    chk("R11 priv handler pc", pc, 16'h1200);
    chk("R11 psr", psr, 16'h0000);
    chk("R11 r6", r6, 16'h2FFE);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule